// File: doc/BRIEF.md
# Multicycle Issue Interlock

This block sits at the issue point of an in-order pipeline whose execution units finish after different numbers of cycles. Each cycle decode presents at most one instruction: its operation class, its destination register and up to two source registers. The interlock tracks every result that is still in flight and either lets the instruction issue or holds it with a stall until every hazard has cleared.

Four kinds of hazard are resolved at issue. A read-after-write hazard exists while a source register is still waiting on a producer. A write-after-write hazard exists when a short-latency writer would overtake a longer one that targets the same register. The single register-file write port may be claimed by only one result per cycle. The divider accepts no new operation until the current one finishes. A countdown per register, a shift register of write-port reservations and a divider busy counter together settle all four in one combinational step.

The register index space is unified. Index 0 is a null register: it never holds a pending value. Decode fills index 0 into any source slot that an instruction does not use.

Top module: `issue_interlock`

## Requirements
- R1: While `in_valid` is low, `stall_o` and `issue_o` are both low. After reset nothing is pending, so the first valid instruction issues in the cycle it is presented.
- R2: The class code on `in_class` is 0 integer ALU (1 cycle), 1 load (2), 2 store, 3 branch, 4 FP add (4), 5 FP multiply (7), 6 FP divide (25). Classes 0, 1, 4, 5 and 6 write `in_dst`. Stores and branches write nothing. An instruction issuing in cycle t with latency L writes in cycle t+L.
- R3: An instruction other than a branch or a store may issue in cycle e only if e is at least p+L for each of its sources, where p and L are the issue cycle and latency of that source's latest writer. So a consumer right after a load stalls 1 cycle, and an FP operation right after an FP add stalls 3 cycles.
- R4: For a store, `in_src_a` is the address and obeys R3. `in_src_b` is the store data and may issue one cycle earlier, at p+L-1. So a store right after an FP add stalls 2 cycles.
- R5: Both branch sources are needed one cycle later than R3 allows, at p+L+1. So a branch right after an integer ALU op stalls 1 cycle.
- R6: A writer stalls while its write cycle would not fall strictly after the pending write cycle of the latest earlier writer of the same destination.
- R7: A writer stalls while another issued writer already holds the write port for the same write cycle.
- R8: A divide stalls until the previous divide has run for 25 cycles. The earliest next issue is 25 cycles after it.
- R9: Register 0 never creates a hazard, whether as a source or as a destination. Stores and branches reserve no write port and leave no pending write.
- R10: A stalled instruction records nothing. Over a repeated load, FP add, store, pointer decrement and branch loop, the total stall count equals that of a latency model that applies R3 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented |
| in_class | input | 3 | Operation class code (R2) |
| in_dst | input | 6 | Destination register, 0 = none |
| in_src_a | input | 6 | First source register (address for a store), 0 = none |
| in_src_b | input | 6 | Second source register (data for a store), 0 = none |
| stall_o | output | 1 | Instruction is held this cycle |
| issue_o | output | 1 | Instruction issues at the coming clock edge |

## Verification
The assertions assume that decode holds class, destination and sources steady for as long as `stall_o` is high. They also assume that an unused source slot carries register 0 and that no class code 7 arrives. The bench presents each instruction and keeps every field fixed until it sees `issue_o`, then changes the fields only at the following falling edge. It uses only the seven defined class codes and fills unused sources with register 0. Under those conditions the assertions on the read, overwrite, write-port and divider conditions describe the interlock itself and never a side effect of changing stimulus.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
   typedef enum logic [2:0] {
      OP_INT    = 3'd0,
      OP_LOAD   = 3'd1,
      OP_STORE  = 3'd2,
      OP_BRANCH = 3'd3,
      OP_FADD   = 3'd4,
      OP_FMUL   = 3'd5,
      OP_FDIV   = 3'd6
   } op_class_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard #(
   parameter  int NREGS = 64,
   parameter  int CW    = 5,
   localparam int RW    = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_en,
   input  logic [RW-1:0] set_reg,
   input  logic [CW-1:0] set_cnt,
   input  logic [RW-1:0] src_a,
   input  logic [RW-1:0] src_b,
   input  logic [CW-1:0] thr_a,
   input  logic [CW-1:0] thr_b,
   input  logic [RW-1:0] dst,
   input  logic [CW-1:0] new_lat,
   output logic          raw_hit,
   output logic          waw_hit
);
   logic [CW-1:0] remain [NREGS];

   for (genvar r = 0; r < NREGS; r++) begin : g_reg
      if (r == 0) begin : g_null
         assign remain[r] = '0;
      end else begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               remain[r] <= '0;
            else if (set_en && set_reg == RW'(r))
               remain[r] <= set_cnt;
            else if (remain[r] != '0)
               remain[r] <= remain[r] - 1'b1;
         end
      end
   end

   always_comb begin
      raw_hit = ((src_a != '0) && (remain[src_a] > thr_a)) ||
                ((src_b != '0) && (remain[src_b] > thr_b));
      waw_hit = (dst != '0) && (new_lat < remain[dst]);
   end
endmodule

// File: rtl/ilk_wport.sv
module ilk_wport #(
   parameter  int SLOTS = 26,
   localparam int LW    = $clog2(SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] query_lat,
   input  logic          take_en,
   output logic          slot_busy
);
   logic [SLOTS-1:0] booked, booked_n;

   assign slot_busy = booked[query_lat];

   always_comb begin
      booked_n = booked >> 1;
      if (take_en)
         booked_n[query_lat - 1'b1] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) booked <= '0;
      else        booked <= booked_n;
   end

   // R7
   port_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_en |-> !slot_busy);
endmodule

// File: rtl/ilk_divbusy.sv
module ilk_divbusy #(
   parameter int LAT_FDIV = 25,
   parameter int CW       = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   logic [CW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            left <= '0;
      else if (start)        left <= CW'(LAT_FDIV - 1);
      else if (left != '0)   left <= left - 1'b1;
   end

   assign busy = (left != '0);

   // R8
   div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
   import ilk_pkg::*;
#(
   parameter  int NREGS         = 64,
   parameter  int LAT_INT       = 1,
   parameter  int LAT_MEM       = 2,
   parameter  int LAT_FADD      = 4,
   parameter  int LAT_FMUL      = 7,
   parameter  int LAT_FDIV      = 25,
   parameter  bit DIV_PIPELINED = 1'b0,
   localparam int RW            = $clog2(NREGS),
   localparam int LAT_MAX       = max_int(max_int(max_int(LAT_INT, LAT_MEM),
                                          max_int(LAT_FADD, LAT_FMUL)), LAT_FDIV),
   localparam int SLOTS         = LAT_MAX + 1,
   localparam int CW            = $clog2(SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [2:0]    in_class,
   input  logic [RW-1:0] in_dst,
   input  logic [RW-1:0] in_src_a,
   input  logic [RW-1:0] in_src_b,
   output logic          stall_o,
   output logic          issue_o
);
   initial begin
      size_chk: assert (NREGS >= 2 && (1 << RW) == NREGS)
         else $error("NREGS must be a power of two");
      lat_chk: assert (LAT_INT >= 1 && LAT_MEM >= 1 && LAT_FADD >= 1 &&
                       LAT_FMUL >= 1 && LAT_FDIV >= 2)
         else $error("latencies out of range");
   end

   op_class_e     cls;
   logic          writes_cls, writes, is_div;
   logic [CW-1:0] lat, thr_a, thr_b;
   logic          raw_hit, waw_hit, port_busy, div_busy, hazard, take;

   assign cls = op_class_e'(in_class);

   always_comb begin
      writes_cls = 1'b1;
      lat        = CW'(LAT_INT);
      unique case (cls)
         OP_INT:    lat = CW'(LAT_INT);
         OP_LOAD:   lat = CW'(LAT_MEM);
         OP_FADD:   lat = CW'(LAT_FADD);
         OP_FMUL:   lat = CW'(LAT_FMUL);
         OP_FDIV:   lat = CW'(LAT_FDIV);
         default:   writes_cls = 1'b0;
      endcase
      writes = writes_cls && (in_dst != '0);
      is_div = (cls == OP_FDIV);
      thr_a  = (cls == OP_BRANCH) ? CW'(0) : CW'(1);
      thr_b  = (cls == OP_BRANCH) ? CW'(0) : (cls == OP_STORE) ? CW'(2) : CW'(1);
   end

   ilk_scoreboard #(.NREGS(NREGS), .CW(CW)) u_sb (
      .clk(clk), .rst_n(rst_n),
      .set_en(take), .set_reg(in_dst), .set_cnt(lat),
      .src_a(in_src_a), .src_b(in_src_b), .thr_a(thr_a), .thr_b(thr_b),
      .dst(in_dst), .new_lat(lat),
      .raw_hit(raw_hit), .waw_hit(waw_hit)
   );

   ilk_wport #(.SLOTS(SLOTS)) u_wp (
      .clk(clk), .rst_n(rst_n),
      .query_lat(lat), .take_en(take), .slot_busy(port_busy)
   );

   if (DIV_PIPELINED) begin : g_div_pipe
      assign div_busy = 1'b0;
   end else begin : g_div_block
      ilk_divbusy #(.LAT_FDIV(LAT_FDIV), .CW(CW)) u_div (
         .clk(clk), .rst_n(rst_n), .start(issue_o && is_div), .busy(div_busy)
      );

      // R8
      div_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (issue_o && is_div) |=> div_busy);
   end

   assign hazard  = raw_hit || (writes && (waw_hit || port_busy)) || (is_div && div_busy);
   assign issue_o = in_valid && !hazard;
   assign stall_o = in_valid && hazard;
   assign take    = issue_o && writes;

   // R3
   no_raw_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_o |-> !raw_hit);

   // R6
   no_waw_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_o && writes) |-> !waw_hit);

   // R10
   held_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |=> (in_valid && $stable(in_class) && $stable(in_dst)));
endmodule

// File: tb/sim_issue_interlock.sv
module sim_issue_interlock;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [2:0] in_class = 3'd0;
   logic [5:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
   logic stall_o, issue_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   int  wr_at [64];
   int  last_div = -1000;
   bit  booked [0:8191];

   issue_interlock u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
      .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
      .stall_o(stall_o), .issue_o(issue_o)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int lat_of(input int c);
      case (c)
         0: return 1;
         1: return 2;
         4: return 4;
         5: return 7;
         6: return 25;
         default: return 0;
      endcase
   endfunction

   function automatic bit src_ready(input int s, input int slack, input int e);
      if (s == 0) return 1'b1;
      return e >= wr_at[s] - slack;
   endfunction

   function automatic int predict(input int c, input int d, input int a, input int b, input int from);
      int L = lat_of(c);
      bit wr = (L != 0) && (d != 0);
      int sa = (c == 3) ? -1 : 0;
      int sb = (c == 3) ? -1 : (c == 2) ? 1 : 0;
      for (int e = from; e < from + 200; e++) begin
         bit ok = src_ready(a, sa, e) && src_ready(b, sb, e);
         if (wr && e + L <= wr_at[d]) ok = 1'b0;
         if (wr && booked[e + L]) ok = 1'b0;
         if (c == 6 && e < last_div + 25) ok = 1'b0;
         if (ok) return e;
      end
      return -1;
   endfunction

   // presents one instruction, waits for issue, checks the issue cycle; returns stalls seen
   task automatic run(input int c, input int d, input int a, input int b,
                      input string tag, output int stalls, output int exp_st);
      int exp_e, guard;
      exp_e = predict(c, d, a, b, cyc);
      exp_st = exp_e - cyc;
      in_valid = 1'b1; in_class = 3'(c); in_dst = 6'(d);
      in_src_a = 6'(a); in_src_b = 6'(b);
      stalls = 0; guard = 0;
      #1;
      while (!issue_o && guard < 200) begin
         stalls++; guard++;
         @(negedge clk); #1;
      end
      check(issue_o && !stall_o && cyc == exp_e, tag, cyc, exp_e);
      if (lat_of(c) != 0 && d != 0) begin
         wr_at[d] = exp_e + lat_of(c);
         booked[exp_e + lat_of(c)] = 1'b1;
      end
      if (c == 6) last_div = exp_e;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0; in_class = '0; in_dst = '0; in_src_a = '0; in_src_b = '0;
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      int s, e;
      #1;
      check(!stall_o && !issue_o, "R1 idle outputs", int'(stall_o) + int'(issue_o), 0);
      run(0, 5, 0, 0, "R1 first issue", s, e);
      check(s == 0, "R1 no stall after reset", s, 0);
      idle(3);
      #1;
      check(!stall_o && !issue_o, "R1 idle after issue", int'(stall_o) + int'(issue_o), 0);
   endtask

   task automatic t_raw;
      int s, e;
      run(1, 32, 1, 0, "R2 load", s, e);
      run(4, 36, 32, 34, "R3 load-use", s, e);
      check(s == 1, "R3 load-use stalls", s, 1);
      run(4, 38, 36, 0, "R3 fp-fp", s, e);
      check(s == 3, "R3 fp-fp stalls", s, 3);
      run(4, 40, 34, 0, "R2 fadd", s, e);
      run(2, 0, 1, 40, "R4 fp-store", s, e);
      check(s == 2, "R4 fp-store stalls", s, 2);
      run(0, 2, 1, 0, "R2 int", s, e);
      run(0, 3, 2, 0, "R3 int-int", s, e);
      check(s == 0, "R3 int-int no stall", s, 0);
      run(3, 0, 3, 0, "R5 int-branch", s, e);
      check(s == 1, "R5 int-branch stalls", s, 1);
      idle(30);
   endtask

   task automatic t_waw_port;
      int s, e;
      run(5, 44, 0, 0, "R2 fmul", s, e);
      run(4, 44, 0, 0, "R6 waw", s, e);
      check(s == 3, "R6 waw stalls", s, 3);
      idle(20);
      run(5, 45, 0, 0, "R2 fmul", s, e);
      run(0, 6, 0, 0, "R7 int a", s, e);
      run(0, 7, 0, 0, "R7 int b", s, e);
      run(4, 46, 0, 0, "R7 port clash", s, e);
      check(s == 1, "R7 port stalls", s, 1);
      idle(20);
   endtask

   task automatic t_div_null;
      int s, e;
      run(6, 50, 0, 0, "R8 div a", s, e);
      run(6, 51, 0, 0, "R8 div b", s, e);
      check(s == 24, "R8 div busy stalls", s, 24);
      idle(40);
      run(1, 0, 1, 0, "R9 load to r0", s, e);
      run(4, 40, 0, 0, "R9 reads r0", s, e);
      check(s == 0, "R9 r0 no stall", s, 0);
      run(2, 40, 1, 0, "R9 store", s, e);
      run(3, 0, 0, 0, "R9 branch", s, e);
      run(4, 40, 0, 0, "R9 after store", s, e);
      check(s == 0, "R9 store leaves nothing", s, 0);
      idle(20);
   endtask

   task automatic t_loop;
      int s, e, tot_s, tot_e;
      tot_s = 0; tot_e = 0;
      for (int it = 0; it < 6; it++) begin
         run(1, 32, 1, 0, "R10 loop load", s, e);   tot_s += s; tot_e += e;
         run(4, 36, 32, 34, "R10 loop fadd", s, e); tot_s += s; tot_e += e;
         run(2, 0, 1, 36, "R10 loop store", s, e);  tot_s += s; tot_e += e;
         run(0, 1, 1, 0, "R10 loop dec", s, e);     tot_s += s; tot_e += e;
         run(3, 0, 1, 2, "R10 loop branch", s, e);  tot_s += s; tot_e += e;
      end
      check(tot_s == tot_e, "R10 loop total stalls", tot_s, tot_e);
      check(tot_s == 24, "R10 loop stalls per model", tot_s, 24);
      idle(5);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int r = 0; r < 64; r++) wr_at[r] = -1000;
      for (int k = 0; k < 8192; k++) booked[k] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_raw();
      t_waw_port();
      t_div_null();
      t_loop();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule